// File: doc/BRIEF.md
# Three-Wire Register Write Slave

This block receives register writes over a three-wire serial link made of a serial clock, an active-low load strobe and a data line. All three pins are oversampled in the system clock domain. Each completed write leaves the block as a one-cycle strobe with its address and data. There are two kinds of frame. A control frame carries a single 24-bit value for one address. A bank frame carries a bank address, a first and a last word index, and then a run of 32-bit words. The first 8 bits of every frame hold the address, and that address decides which kind of frame it is.

In a bank frame, a first and last index of zero together select a full-bank burst. A burst must supply every word of the bank, and the load strobe is disregarded until the last word has arrived. Any other index pair selects a range of words written in ascending order. Raising the load strobe ends such a range early, and the words already completed are kept. After reset, a lockout interval keeps any frame from starting until the block's internal initialisation time has passed.

Top module: `twr_serial_writer`

## Requirements
- R1: Bits are taken MSB first on each rising serial-clock edge while load is low. A control frame is 8 address bits followed by 24 data bits. After the 32nd bit, exactly one `ctl_wr` pulse carries that address and data.
- R2: If load rises before all 32 header bits have arrived, the frame is dropped and produces no write of either kind.
- R3: A new frame starts only if load has been high across at least one rising serial-clock edge since the previous frame. If load drops again without such an edge, that whole low period is ignored.
- R4: An address in the range BANK_BASE to BANK_BASE+NUM_BANKS-1 makes a bank frame. Its header is 8 address bits, then a 12-bit first index, then a 12-bit last index, all MSB first. Every other address, including BANK_BASE-1 and BANK_BASE+NUM_BANKS, makes a control frame.
- R5: When both indices are zero, the bank frame is a burst. It writes indices 0 to BANK_WORDS-1 in order, one `bank_wr` pulse per 32-bit word.
- R6: During a burst, a rise or fall of load does not end or restart the frame. Every word of the bank is still written.
- R7: In a range frame, words are written at indices first, first+1, and so on up to last. For example, first 2 and last 4 give three writes.
- R8: A load rise in a range frame before the last index is reached ends the frame. Completed words stay written, and a partial word is discarded.
- R9: A last index beyond the bank is treated as BANK_WORDS-1. A last index below the first index writes the first index only. A first index at or beyond BANK_WORDS produces no write.
- R10: For LOCK_CYCLES clock cycles after reset, no frame can start, so no write is produced from a load fall in that window.
- R11: During and directly after reset, both strobes are low and all address, index and data outputs are zero.
- R12: Once the last word of a range has been written, further bits shifted in while load stays low produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_load_n | input | 1 | Active-low frame strobe |
| ser_data | input | 1 | Serial data, MSB first |
| ctl_wr | output | 1 | One-cycle strobe for a completed control write |
| ctl_addr | output | 8 | Control write address |
| ctl_data | output | 24 | Control write data |
| bank_wr | output | 1 | One-cycle strobe for a completed bank word |
| bank_sel | output | 8 | Bank address of the word |
| bank_idx | output | 12 | Word index inside the bank |
| bank_data | output | 32 | Word data |

## Verification
A corrupted bit counter or shift register shows up directly at the ports. The write strobe fires on the wrong serial edge, or the captured address, index or data is off by one bit position, and this is visible at the first write of the frame. A wrong state after a burst or abort decision shows up in the write count: words are missing, extra, or have non-ascending indices before the frame's load rise has settled. A lockout or frame-gap error appears as a write that should not exist, or a write that should exist and is missing, a few cycles after the 32nd bit of the affected frame.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int ADDR_W = 8;
    localparam int IDX_W  = 12;
    localparam int WORD_W = 32;
    localparam int CTL_W  = 24;
    localparam int HDR_W  = ADDR_W + 2 * IDX_W;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_DRAIN
    } seq_state_t;

    // Header layout: address bits arrive first, so they sit at the top.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  first;
        logic [IDX_W-1:0]  last;
    } hdr_t;

    function automatic logic is_bank_addr(input logic [ADDR_W-1:0] a,
                                          input int unsigned base,
                                          input int unsigned count);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base + count));
    endfunction

    function automatic logic is_burst(input hdr_t h);
        return (h.first == '0) && (h.last == '0);
    endfunction

    // Final index of a bank frame after clamping to the bank size.
    function automatic logic [IDX_W-1:0] final_index(input hdr_t h,
                                                     input int unsigned words);
        logic [IDX_W-1:0] top;
        logic [IDX_W-1:0] stop;
        top = IDX_W'(words - 1);
        if (is_burst(h)) begin
            stop = top;
        end else begin
            stop = (h.last > top) ? top : h.last;
            if (stop < h.first) stop = h.first;
        end
        return stop;
    endfunction

endpackage

// File: rtl/twr_pin_sampler.sv
module twr_pin_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_pin,
    input  logic load_n_pin,
    input  logic sda_pin,
    output logic sck_rise,
    output logic load_hi,
    output logic load_rise,
    output logic load_fall,
    output logic sda_bit
);
    // Pin order inside each stage: {sda, load_n, sck}
    localparam logic [2:0] IDLE_PINS = 3'b010;

    logic [2:0] stage_q [STAGES];
    logic [2:0] prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= IDLE_PINS;
                    else     stage_q[g] <= {sda_pin, load_n_pin, sck_pin};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= IDLE_PINS;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE_PINS;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign sck_rise  =  stage_q[STAGES-1][0] & ~prev_q[0];
    assign load_hi   =  stage_q[STAGES-1][1];
    assign load_rise =  stage_q[STAGES-1][1] & ~prev_q[1];
    assign load_fall = ~stage_q[STAGES-1][1] &  prev_q[1];
    assign sda_bit   =  stage_q[STAGES-1][2];

endmodule

// File: rtl/twr_lockout.sv
module twr_lockout #(
    parameter int unsigned LOCK_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                              cnt_q <= '0;
        else if (cnt_q != CNT_W'(LOCK_CYCLES)) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == CNT_W'(LOCK_CYCLES));

endmodule

// File: rtl/twr_sequencer.sv
module twr_sequencer
    import twr_pkg::*;
#(
    parameter int unsigned BANK_BASE  = 8'h14,
    parameter int unsigned NUM_BANKS  = 5,
    parameter int unsigned BANK_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sck_rise,
    input  logic              load_hi,
    input  logic              load_rise,
    input  logic              load_fall,
    input  logic              sda_bit,
    output logic              ctl_wr,
    output logic [ADDR_W-1:0] ctl_addr,
    output logic [CTL_W-1:0]  ctl_data,
    output logic              bank_wr,
    output logic [ADDR_W-1:0] bank_sel,
    output logic [IDX_W-1:0]  bank_idx,
    output logic [WORD_W-1:0] bank_data
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_t        state_q;
    logic [WORD_W-1:0] shift_q;
    logic [BIT_W-1:0]  bit_q;
    logic [ADDR_W-1:0] sel_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  stop_q;
    logic              burst_q;
    logic              gap_ok_q;

    logic [WORD_W-1:0] shift_nxt;
    hdr_t              hdr;
    logic              hdr_bank;
    logic              hdr_burst;
    logic              hdr_empty;

    always_comb begin
        shift_nxt = {shift_q[WORD_W-2:0], sda_bit};
        hdr       = hdr_t'(shift_nxt[HDR_W-1:0]);
        hdr_bank  = is_bank_addr(hdr.addr, BANK_BASE, NUM_BANKS);
        hdr_burst = is_burst(hdr);
        hdr_empty = !hdr_burst && (int'(hdr.first) >= int'(BANK_WORDS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            shift_q   <= '0;
            bit_q     <= '0;
            sel_q     <= '0;
            idx_q     <= '0;
            stop_q    <= '0;
            burst_q   <= 1'b0;
            gap_ok_q  <= 1'b1;
            ctl_wr    <= 1'b0;
            ctl_addr  <= '0;
            ctl_data  <= '0;
            bank_wr   <= 1'b0;
            bank_sel  <= '0;
            bank_idx  <= '0;
            bank_data <= '0;
        end else begin
            ctl_wr  <= 1'b0;
            bank_wr <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (load_hi && sck_rise) gap_ok_q <= 1'b1;
                    if (load_fall && enable && gap_ok_q) begin
                        state_q  <= ST_HDR;
                        bit_q    <= '0;
                        gap_ok_q <= 1'b0;
                    end
                end
                ST_HDR: begin
                    if (load_rise) begin
                        state_q <= ST_IDLE;
                    end else if (sck_rise) begin
                        shift_q <= shift_nxt;
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            if (!hdr_bank) begin
                                ctl_wr   <= 1'b1;
                                ctl_addr <= hdr.addr;
                                ctl_data <= shift_nxt[CTL_W-1:0];
                                state_q  <= ST_DRAIN;
                            end else if (hdr_empty) begin
                                state_q <= ST_DRAIN;
                            end else begin
                                sel_q   <= hdr.addr;
                                idx_q   <= hdr_burst ? '0 : hdr.first;
                                stop_q  <= final_index(hdr, BANK_WORDS);
                                burst_q <= hdr_burst;
                                state_q <= ST_DATA;
                            end
                        end
                    end
                end
                ST_DATA: begin
                    if (load_rise && !burst_q) begin
                        state_q <= ST_IDLE;
                    end else if (sck_rise) begin
                        shift_q <= shift_nxt;
                        bit_q   <= bit_q + 1'b1;
                        if (bit_q == LAST_BIT) begin
                            bank_wr   <= 1'b1;
                            bank_sel  <= sel_q;
                            bank_idx  <= idx_q;
                            bank_data <= shift_nxt;
                            if (idx_q == stop_q) state_q <= ST_DRAIN;
                            else                 idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (load_hi) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/twr_serial_writer.sv
module twr_serial_writer
    import twr_pkg::*;
#(
    parameter int unsigned BANK_BASE   = 8'h14,
    parameter int unsigned NUM_BANKS   = 5,
    parameter int unsigned BANK_WORDS  = 16,
    parameter int unsigned LOCK_CYCLES = 4096,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk,
    input  logic        ser_load_n,
    input  logic        ser_data,
    output logic        ctl_wr,
    output logic [7:0]  ctl_addr,
    output logic [23:0] ctl_data,
    output logic        bank_wr,
    output logic [7:0]  bank_sel,
    output logic [11:0] bank_idx,
    output logic [31:0] bank_data
);
    logic ready;
    logic sck_rise;
    logic load_hi;
    logic load_rise;
    logic load_fall;
    logic sda_bit;

    twr_pin_sampler #(.STAGES(SYNC_STAGES)) u_pins (
        .clk        (clk),
        .rst        (rst),
        .sck_pin    (ser_clk),
        .load_n_pin (ser_load_n),
        .sda_pin    (ser_data),
        .sck_rise   (sck_rise),
        .load_hi    (load_hi),
        .load_rise  (load_rise),
        .load_fall  (load_fall),
        .sda_bit    (sda_bit)
    );

    twr_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .ready (ready)
    );

    twr_sequencer #(
        .BANK_BASE  (BANK_BASE),
        .NUM_BANKS  (NUM_BANKS),
        .BANK_WORDS (BANK_WORDS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (ready),
        .sck_rise  (sck_rise),
        .load_hi   (load_hi),
        .load_rise (load_rise),
        .load_fall (load_fall),
        .sda_bit   (sda_bit),
        .ctl_wr    (ctl_wr),
        .ctl_addr  (ctl_addr),
        .ctl_data  (ctl_data),
        .bank_wr   (bank_wr),
        .bank_sel  (bank_sel),
        .bank_idx  (bank_idx),
        .bank_data (bank_data)
    );

endmodule

// File: rtl/twr_writer_checker.sv
module twr_writer_checker #(
    parameter int unsigned BANK_BASE   = 8'h14,
    parameter int unsigned NUM_BANKS   = 5,
    parameter int unsigned BANK_WORDS  = 16,
    parameter int unsigned LOCK_CYCLES = 4096
) (
    input logic        clk,
    input logic        rst,
    input logic        ctl_wr,
    input logic [7:0]  ctl_addr,
    input logic        bank_wr,
    input logic [7:0]  bank_sel,
    input logic [11:0] bank_idx
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] since_rst_q;

    always_ff @(posedge clk) begin
        if (rst)                                    since_rst_q <= '0;
        else if (since_rst_q != CNT_W'(LOCK_CYCLES)) since_rst_q <= since_rst_q + 1'b1;
    end

    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q < CNT_W'(LOCK_CYCLES)) |-> (!ctl_wr && !bank_wr)); // R10

    AST_IDX_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        bank_wr |-> (int'(bank_idx) < int'(BANK_WORDS))); // R9

    AST_SEL_IN_BANKS: assert property (@(posedge clk) disable iff (rst)
        bank_wr |-> ((int'(bank_sel) >= int'(BANK_BASE)) &&
                     (int'(bank_sel) < int'(BANK_BASE + NUM_BANKS)))); // R4

    AST_CTL_OUTSIDE_BANKS: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |-> ((int'(ctl_addr) < int'(BANK_BASE)) ||
                    (int'(ctl_addr) >= int'(BANK_BASE + NUM_BANKS)))); // R4

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr && bank_wr)); // R1

    AST_BANK_PULSE: assert property (@(posedge clk) disable iff (rst)
        bank_wr |=> !bank_wr); // R5

    AST_CTL_PULSE: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> !ctl_wr); // R1

endmodule

bind twr_serial_writer twr_writer_checker #(
    .BANK_BASE   (BANK_BASE),
    .NUM_BANKS   (NUM_BANKS),
    .BANK_WORDS  (BANK_WORDS),
    .LOCK_CYCLES (LOCK_CYCLES)
) u_checker (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_addr (ctl_addr),
    .bank_wr  (bank_wr),
    .bank_sel (bank_sel),
    .bank_idx (bank_idx)
);

// File: tb/tb_twr_serial_writer.sv
module tb_twr_serial_writer;

    localparam int unsigned BASE  = 8'h14;
    localparam int unsigned NB    = 5;
    localparam int unsigned WORDS = 6;
    localparam int unsigned LOCK  = 300;
    localparam int          HALF  = 4;
    localparam int          NLOG  = 128;

    logic        clk = 1'b0;
    logic        rst;
    logic        sck, sld, sda;
    logic        ctl_wr, bank_wr;
    logic [7:0]  ctl_addr, bank_sel;
    logic [23:0] ctl_data;
    logic [11:0] bank_idx;
    logic [31:0] bank_data;

    always #5 clk = ~clk;

    twr_serial_writer #(
        .BANK_BASE(BASE), .NUM_BANKS(NB), .BANK_WORDS(WORDS), .LOCK_CYCLES(LOCK)
    ) dut (
        .clk(clk), .rst(rst), .ser_clk(sck), .ser_load_n(sld), .ser_data(sda),
        .ctl_wr(ctl_wr), .ctl_addr(ctl_addr), .ctl_data(ctl_data),
        .bank_wr(bank_wr), .bank_sel(bank_sel), .bank_idx(bank_idx), .bank_data(bank_data)
    );

    // Write log filled from the output ports
    int          c_cnt = 0;
    int          b_cnt = 0;
    logic [7:0]  c_addr [NLOG];
    logic [23:0] c_data [NLOG];
    logic [7:0]  b_sel  [NLOG];
    logic [11:0] b_idx  [NLOG];
    logic [31:0] b_data [NLOG];

    always @(negedge clk) begin
        if (ctl_wr) begin
            if (c_cnt < NLOG) begin
                c_addr[c_cnt] <= ctl_addr;
                c_data[c_cnt] <= ctl_data;
            end
            c_cnt <= c_cnt + 1;
        end
        if (bank_wr) begin
            if (b_cnt < NLOG) begin
                b_sel[b_cnt]  <= bank_sel;
                b_idx[b_cnt]  <= bank_idx;
                b_data[b_cnt] <= bank_data;
            end
            b_cnt <= b_cnt + 1;
        end
    end

    typedef struct packed {
        logic [7:0]  addr;
        logic [11:0] first;
        logic [11:0] last;
        logic [23:0] cdata;
        logic [7:0]  nsend;
        logic [7:0]  nexp;
        logic [7:0]  start;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h05, 12'd0, 12'd0,  24'h123456, 8'd0, 8'd0, 8'd0},  // R1 control
        '{8'h19, 12'd0, 12'd0,  24'hABCDEF, 8'd0, 8'd0, 8'd0},  // R4 above banks
        '{8'h13, 12'd0, 12'd0,  24'h0F0F0F, 8'd0, 8'd0, 8'd0},  // R4 below banks
        '{8'h15, 12'd2, 12'd4,  24'h0,      8'd3, 8'd3, 8'd2},  // R7 range
        '{8'h14, 12'd0, 12'd0,  24'h0,      8'd6, 8'd6, 8'd0},  // R5 burst
        '{8'h16, 12'd3, 12'd9,  24'h0,      8'd3, 8'd3, 8'd3},  // R9 end clamp
        '{8'h17, 12'd4, 12'd1,  24'h0,      8'd1, 8'd1, 8'd4},  // R9 end below start
        '{8'h18, 12'd1, 12'd4,  24'h0,      8'd2, 8'd2, 8'd1},  // R8 abort
        '{8'h16, 12'd9, 12'd10, 24'h0,      8'd1, 8'd0, 8'd0},  // R9 start beyond
        '{8'h15, 12'd5, 12'd5,  24'h0,      8'd2, 8'd1, 8'd5}   // R12 trailing word
    };

    function automatic string vtag(input int v);
        case (v)
            0:       return "R1";
            1, 2:    return "R4";
            3:       return "R7";
            4:       return "R5";
            7:       return "R8";
            9:       return "R12";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] wdata(input int v, input int k);
        return {8'(v), 8'hC3, 8'(k), 8'(v ^ (k * 7))};
    endfunction

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sda = b;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(val[i]);
    endtask

    task automatic open_frame(input bit gap);
        if (gap) pulse(1'b0);
        wait_clk(HALF);
        sld = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic close_frame();
        wait_clk(HALF);
        sld = 1'b1;
        wait_clk(HALF + 10);
    endtask

    task automatic ctl_frame(input logic [7:0] a, input logic [23:0] d, input bit gap);
        open_frame(gap);
        send_bits({a, d}, 32);
        close_frame();
    endtask

    task automatic run_vector(input int v);
        vec_t t;
        int   c0, b0;
        bit   ctl;
        t   = VECS[v];
        c0  = c_cnt;
        b0  = b_cnt;
        ctl = !((int'(t.addr) >= int'(BASE)) && (int'(t.addr) < int'(BASE + NB)));
        open_frame(1'b1);
        if (ctl) begin
            send_bits({t.addr, t.cdata}, 32);
        end else begin
            send_bits({t.addr, t.first, t.last}, 32);
            for (int k = 0; k < int'(t.nsend); k++) send_bits(wdata(v, k), 32);
        end
        close_frame();
        check(c_cnt - c0 == (ctl ? 1 : 0), vtag(v), c_cnt - c0, ctl ? 1 : 0);
        check(b_cnt - b0 == int'(t.nexp), vtag(v), b_cnt - b0, t.nexp);
        if (ctl && c_cnt > c0) begin
            check(c_addr[c0] == t.addr, vtag(v), c_addr[c0], t.addr);
            check(c_data[c0] == t.cdata, vtag(v), c_data[c0], t.cdata);
        end
        if (!ctl && b_cnt - b0 == int'(t.nexp)) begin
            for (int k = 0; k < int'(t.nexp); k++) begin
                check(b_sel[b0+k] == t.addr, vtag(v), b_sel[b0+k], t.addr);
                check(b_idx[b0+k] == 12'(t.start + k), vtag(v), b_idx[b0+k], t.start + k);
                check(b_data[b0+k] == wdata(v, k), vtag(v), b_data[b0+k], wdata(v, k));
            end
        end
    endtask

    task automatic run_all();
        int c0, b0;
        sck = 1'b0; sld = 1'b1; sda = 1'b0; rst = 1'b1;
        wait_clk(5);
        // R11: outputs idle during reset
        check(!ctl_wr && !bank_wr, "R11", {ctl_wr, bank_wr}, 0);
        check(ctl_addr == 0 && ctl_data == 0, "R11", {ctl_addr, ctl_data}, 0);
        check(bank_sel == 0 && bank_idx == 0 && bank_data == 0, "R11",
              {bank_sel, bank_idx, bank_data}, 0);
        rst = 1'b0;
        // R10: a frame that starts inside the lockout window is dropped
        c0 = c_cnt; b0 = b_cnt;
        ctl_frame(8'h05, 24'h777777, 1'b0);
        wait_clk(LOCK);
        check(c_cnt == c0 && b_cnt == b0, "R10", c_cnt - c0, 0);

        for (int v = 0; v < NV; v++) run_vector(v);

        // R2: header cut short
        c0 = c_cnt; b0 = b_cnt;
        open_frame(1'b1);
        send_bits(32'h0512_3456, 20);
        close_frame();
        check(c_cnt == c0 && b_cnt == b0, "R2", (c_cnt - c0) + (b_cnt - b0), 0);

        // R3: second frame without a serial edge while load is high
        c0 = c_cnt;
        ctl_frame(8'h02, 24'h00AA55, 1'b1);
        ctl_frame(8'h03, 24'h55AA00, 1'b0);
        check(c_cnt - c0 == 1, "R3", c_cnt - c0, 1);
        check(c_addr[c0] == 8'h02, "R3", c_addr[c0], 8'h02);
        c0 = c_cnt;
        ctl_frame(8'h04, 24'h010203, 1'b1);
        check(c_cnt - c0 == 1 && c_data[c0] == 24'h010203, "R3", c_data[c0], 24'h010203);

        // R6: burst survives a load pulse in the middle
        b0 = b_cnt;
        open_frame(1'b1);
        send_bits({8'h18, 12'd0, 12'd0}, 32);
        for (int k = 0; k < int'(WORDS); k++) begin
            if (k == 2) begin
                sld = 1'b1;
                wait_clk(3 * HALF);
                sld = 1'b0;
                wait_clk(HALF);
            end
            send_bits(wdata(20, k), 32);
        end
        close_frame();
        check(b_cnt - b0 == int'(WORDS), "R6", b_cnt - b0, WORDS);
        if (b_cnt - b0 == int'(WORDS)) begin
            for (int k = 0; k < int'(WORDS); k++) begin
                check(b_idx[b0+k] == 12'(k), "R6", b_idx[b0+k], k);
                check(b_data[b0+k] == wdata(20, k), "R6", b_data[b0+k], wdata(20, k));
            end
        end
    endtask

    initial begin
        bit timeout;
        timeout = 1'b0;
        fork
            run_all();
            begin
                wait_clk(150000);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule